// File: doc/BRIEF.md
# E1 Receive National Bits Capture

This block sits behind an existing E1 receive framer and gathers the five national spare bits carried in timeslot 0 of the odd frames, the frames that carry no alignment word. The framer supplies the recovered serial bit stream with a bit enable, a strobe on the first bit of every frame and a strobe on the first bit of every 16-frame multiframe. Each of the five spare bit positions fills its own 8-bit register over one multiframe, one bit from each odd frame.

Captured bits first go into a shadow set. All five readable registers take the shadow contents together at a multiframe boundary, so a read never shows a mix of two multiframes. When the framer reports loss of multiframe alignment, capture and update stop. After alignment returns, the block waits for one complete multiframe before it publishes new values. Software reads the registers through a small combinational read port with a 16-bit data bus.

Top module: `e1_natbits_rx`

## Requirements
- R1: After reset, all five registers read zero.
- R2: Register index k (0 to 4) holds the received timeslot 0 bit at position 4+k, where position 1 is the first bit received after the frame strobe (index 0 is Sa4, index 4 is Sa8).
- R3: Bit j (0 to 7) of each register holds the value from frame 2j+1 of the multiframe, where frame 0 is the frame that starts with the multiframe strobe. Spare bit positions in even frames are ignored.
- R4: Read data bits 15 to 8 are zero. Read addresses 5 to 15 return zero.
- R5: All five registers change together. They change only in the cycle after an enabled bit that carries the multiframe strobe. They then show the multiframe that ended at that strobe. Before that strobe they still show the previous values.
- R6: While the loss-of-multiframe-alignment input is high, no bit is captured and the registers do not change.
- R7: A multiframe boundary arms the update only when loss of alignment is low. Loss of alignment disarms it. The registers load at a boundary only when they are armed, so after a loss the first load happens at the second boundary.
- R8: Input values on cycles where the bit enable is low are ignored, and so are bits outside timeslot 0 positions 4 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Recovered serial data |
| rx_bit_en | input | 1 | Qualifies rx_bit and both strobes |
| rx_frm_start | input | 1 | High with the first bit of each frame |
| rx_mf_start | input | 1 | High with the first bit of frame 0 of a multiframe |
| rx_mf_lost | input | 1 | Framer reports loss of multiframe alignment |
| rd_addr | input | 4 | Register select, 0 to 4 valid |
| rd_data | output | 16 | Read data, register in bits 7 to 0 |

## Verification
The read port has no register, so rd_data follows rd_addr in the same cycle. The bench sets the address and settles for 1 ns before it samples. A register load shows at the clock edge that accepts the boundary bit. The bench therefore checks the old values just before it drives that bit and the new values at the falling edge right after it. Spare bits take about a multiframe to reach the registers, so every boundary is compared against a model of the arm and load rules. Loss-of-alignment periods span whole multiframes.

// File: rtl/e1_natbits_rx.sv
module e1_natbits_rx #(
  parameter int NSA        = 5,
  parameter int FRAMES     = 16,
  parameter int FRAME_BITS = 256,
  parameter int SA_FIRST   = 3,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_bit_en,
  input  logic              rx_frm_start,
  input  logic              rx_mf_start,
  input  logic              rx_mf_lost,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int REG_W = FRAMES / 2;
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam int FRM_W = $clog2(FRAMES);

  logic [POS_W-1:0]           pos_q;
  logic [FRM_W-1:0]           frm_q;
  logic [NSA-1:0][REG_W-1:0]  shad_q, live_q;
  logic                       armed_q;
  logic [REG_W-1:0]           rd_byte;

  wire              new_frm  = rx_frm_start | rx_mf_start;
  wire [POS_W-1:0]  cur_pos  = new_frm ? '0 : pos_q;
  wire [FRM_W-1:0]  cur_frm  = rx_mf_start ? '0 : (rx_frm_start ? frm_q + 1'b1 : frm_q);
  wire [POS_W-1:0]  sa_off   = cur_pos - POS_W'(SA_FIRST);
  wire              sa_hit   = rx_bit_en && !rx_mf_lost && cur_frm[0] &&
                               cur_pos >= POS_W'(SA_FIRST) && cur_pos < POS_W'(SA_FIRST + NSA);
  wire [FRM_W-2:0]  slot     = cur_frm[FRM_W-1:1];
  wire              boundary = rx_bit_en && rx_mf_start;
  wire              commit   = boundary && armed_q && !rx_mf_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      frm_q <= '0;
    end else if (rx_bit_en) begin
      pos_q <= cur_pos + 1'b1;
      frm_q <= cur_frm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (boundary)   armed_q <= !rx_mf_lost;
    else if (rx_mf_lost) armed_q <= 1'b0;
  end

  for (genvar k = 0; k < NSA; k++) begin : g_sa
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shad_q[k] <= '0;
        live_q[k] <= '0;
      end else begin
        if (sa_hit && sa_off == POS_W'(k)) shad_q[k][slot] <= rx_bit;
        if (commit) live_q[k] <= shad_q[k];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NSA; k++)
      if (rd_addr == ADDR_W'(k)) rd_byte = live_q[k];
  end

  assign rd_data = {{(DATA_W-REG_W){1'b0}}, rd_byte};

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:REG_W] == '0);

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr >= ADDR_W'(NSA) |-> rd_data == '0);

  p_update_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_bit_en && rx_mf_start) |=> $stable(live_q));

  p_hold_when_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mf_lost |=> $stable(live_q) && $stable(shad_q));

  p_disarm_on_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mf_lost |=> !armed_q);
endmodule

// File: tb/tb_e1_natbits_rx.sv
module tb_e1_natbits_rx;
  logic clk = 0, rst_n = 0;
  logic rx_bit = 0, rx_bit_en = 0, rx_frm_start = 0, rx_mf_start = 0, rx_mf_lost = 0;
  logic [3:0]  rd_addr = 0;
  logic [15:0] rd_data;
  int tests = 0, fails = 0;
  logic [7:0] exp_r [5];
  logic [7:0] prev_p [5];
  logic armed_m = 0;

  always #5 clk = ~clk;

  e1_natbits_rx dut (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
    .rx_frm_start(rx_frm_start), .rx_mf_start(rx_mf_start), .rx_mf_lost(rx_mf_lost),
    .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [7:0] pat(int m, int k);
    return 8'((m + 1) * 53 + k * 29) ^ 8'h3C;
  endfunction

  function automatic logic bitval(int m, int f, int p);
    if (p >= 3 && p <= 7) begin
      if (f % 2 == 1) return pat(m, p - 3)[(f - 1) / 2];
      return ~pat(m, p - 3)[f / 2];
    end
    return 1'(((f * 13 + p * 7 + m) >> 1) & 1);
  endfunction

  task automatic check(string tag, logic [3:0] a, logic [15:0] e);
    rd_addr = a;
    #1;
    tests++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, e);
    end
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < 5; k++) check(tag, 4'(k), {8'h00, exp_r[k]});
  endtask

  task automatic send_bit(logic b, logic fs, logic ms);
    @(negedge clk);
    rx_bit_en = 1; rx_bit = b; rx_frm_start = fs; rx_mf_start = ms;
    @(negedge clk);
    rx_bit_en = 0; rx_bit = ~b; rx_frm_start = 1; rx_mf_start = 1;  // R8 junk while disabled
  endtask

  task automatic send_mf(int m, logic lost);
    @(negedge clk);
    rx_mf_lost = lost;
    check_all("R5 before boundary");
    if (!lost && armed_m)
      for (int k = 0; k < 5; k++) exp_r[k] = prev_p[k];
    armed_m = !lost;  // R7 arm rule
    send_bit(bitval(m, 0, 0), 1'b1, 1'b1);
    check_all("R2 R3 R5 R6 R7 after boundary");
    for (int f = 0; f < 16; f++)
      for (int p = (f == 0 ? 1 : 0); p < 256; p++)
        send_bit(bitval(m, f, p), p == 0, 1'b0);
    if (!lost)
      for (int k = 0; k < 5; k++) prev_p[k] = pat(m, k);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin exp_r[k] = 0; prev_p[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    for (int a = 5; a < 16; a++) check("R4 reserved", 4'(a), 16'h0000);
    send_mf(0, 0);
    send_mf(1, 0);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a); #1; tests++;
      if (rd_data[15:8] !== 8'h00) begin
        fails++; $display("FAIL R4 upper byte actual %h expected 00", rd_data[15:8]);
      end
    end
    send_mf(2, 0);
    send_mf(3, 1);  // R6
    send_mf(4, 1);
    send_mf(5, 0);  // R7: arms only
    send_mf(6, 0);  // R7: loads pattern 5
    send_mf(7, 0);
    send_mf(8, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule